// File: doc/BRIEF.md
# Multi-Policy Dynamic Bus Arbiter

This block decides which of several bus masters (processors, I/O processors) owns a shared system bus. Each master raises its own request line and sees its own grant line. The arbiter also drives a shared busy line that is high whenever an owner holds the bus. A three-bit policy input selects how priority moves at run time. There are five policies: time slices handed round in turn, a scanning poll pointer, least-recently-used order, arrival order, and a closed-ring daisy chain.

An owner keeps the bus for as long as it holds its request. The one exception is the time-slice policy, where a slot of fixed length ends the tenure. When a tenure ends, the bus is idle for at least one cycle before the next grant. The policy input is examined only in idle cycles. A change of policy uses up one idle cycle and clears the priority state of the newly chosen policy. The state of each policy is kept across tenures for as long as that policy stays selected.

Top module: `mpol_bus_arbiter`

## Requirements
- R1: At most one grant is high in any cycle, and busy is high exactly when a grant is high.
- R2: During reset and after it, no grant is given until a request arrives. The active policy after reset is the time-slice policy, with its search pointer at index 0.
- R3: A grant is given only to a unit whose request was high in the cycle before. The owner keeps its grant while its request stays high, except at the end of a time slice. The grant falls on the first edge at which the owner's request is seen low.
- R4: Policy code 0 (time slice) ends a tenure after SLICE_LEN granted cycles. The next owner is the first requesting unit in ascending circular order, starting just after the last owner. Units that are not requesting are passed over in the same cycle, so there is exactly one idle cycle between tenures.
- R5: Policy code 1 (polling) advances a pointer by one index in each idle cycle. It grants the pointed unit if that unit is requesting. After a grant, scanning resumes at the index after the owner.
- R6: Policy code 2 (LRU) grants the requesting unit that has gone longest without a tenure. A unit moves to most-recent when its tenure ends. The order after a clear is ascending index, with index 0 as the least recent.
- R7: Policy code 3 (arrival order) grants requests in the order in which they first rose. Requests that rise in the same cycle are queued lowest index first.
- R8: Policy code 4 (closed ring) grants the first requesting unit after the last owner, wrapping from the top index back to 0. There is no limit on tenure length.
- R9: Codes 5 to 7 act as code 4. The policy input has no effect while busy is high. In an idle cycle, a new code takes effect with no grant in that cycle, and it clears the pointer to 0, the LRU order to ascending, and the arrival queue to empty.
- R10: Under every policy, a unit that holds its request until served gets a tenure within a bounded time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Policy code, looked at only while the bus is idle |
| req_i | input | NREQ | One request line per unit |
| gnt_o | output | NREQ | One grant line per unit, one-hot or zero |
| busy_o | output | 1 | Shared bus busy line |

## Verification
The hardest situation to reach from the ports is one where queued arrival order, LRU order and ring order would each pick a different winner. Only then does a wrong policy show up as a wrong grant. The stimulus builds this case in several steps. It holds one unit on the bus, staggers new requests into the cycles of that tenure, and toggles the policy input while the bus is busy. The scoreboard then expects exactly one order, together with the tenure lengths and the idle gaps. Random traffic under every policy then checks that no unit waits without bound.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  typedef enum logic [2:0] {
    POL_SLICE = 3'd0,
    POL_POLL  = 3'd1,
    POL_LRU   = 3'd2,
    POL_FIFO  = 3'd3,
    POL_RING  = 3'd4
  } policy_e;
endpackage

// File: rtl/mpa_ring_pick.sv
module mpa_ring_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] cand;

  // first requester at or after start, circular; lowest offset wins
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    cand = '0;
    for (int i = N - 1; i >= 0; i--) begin
      cand = IW'((int'(start) + i) % N);
      if (req[cand]) begin
        hit = 1'b1;
        idx = cand;
      end
    end
  end
endmodule

// File: rtl/mpa_lru_order.sv
module mpa_lru_order #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [IW-1:0] upd_idx,
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] win
);
  logic [IW-1:0] ord_q [N];
  logic [IW-1:0] ord_d [N];
  int            pos;

  // slot 0 holds the least recently used unit
  always_comb begin
    pos = N - 1;
    for (int i = N - 1; i >= 0; i--)
      if (ord_q[i] == upd_idx) pos = i;
    for (int i = 0; i < N; i++) begin
      if (clr)                       ord_d[i] = IW'(i);
      else if (upd && i == N - 1)    ord_d[i] = upd_idx;
      else if (upd && i >= pos)      ord_d[i] = ord_q[(i + 1) % N];
      else                           ord_d[i] = ord_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ord_q[i] <= IW'(i);
    end else if (clr || upd) begin
      for (int i = 0; i < N; i++) ord_q[i] <= ord_d[i];
    end
  end

  always_comb begin
    hit = 1'b0;
    win = ord_q[0];
    for (int i = N - 1; i >= 0; i--) begin
      if (req[ord_q[i]]) begin
        hit = 1'b1;
        win = ord_q[i];
      end
    end
  end
endmodule

// File: rtl/mpa_arrival_queue.sv
module mpa_arrival_queue #(
  parameter int N    = 4,
  parameter int IW   = 2,
  parameter int CNTW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pop,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  hold,
  output logic          vld,
  output logic [IW-1:0] head
);
  logic [IW-1:0]   slot_q [N];
  logic [IW-1:0]   slot_d [N];
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [N-1:0]    inq_q, inq_d;
  logic            do_pop;

  assign vld    = (cnt_q != '0);
  assign head   = slot_q[0];
  assign do_pop = pop && vld;

  always_comb begin
    for (int i = 0; i < N; i++) slot_d[i] = slot_q[i];
    cnt_d = cnt_q;
    inq_d = inq_q;
    if (clr) begin
      cnt_d = '0;
      inq_d = '0;
    end else begin
      if (do_pop) begin
        inq_d[slot_q[0]] = 1'b0;
        for (int i = 0; i < N; i++) slot_d[i] = slot_q[(i + 1) % N];
        cnt_d = cnt_q - 1'b1;
      end
      // new arrivals enter in ascending index order
      for (int i = 0; i < N; i++) begin
        if (req[i] && !inq_d[i] && !hold[i] &&
            !(do_pop && slot_q[0] == IW'(i))) begin
          slot_d[cnt_d[IW-1:0]] = IW'(i);
          cnt_d    = cnt_d + 1'b1;
          inq_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      inq_q <= '0;
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      inq_q <= inq_d;
      for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
    end
  end
endmodule

// File: rtl/mpol_bus_arbiter.sv
module mpol_bus_arbiter
  import mpa_pkg::*;
#(
  parameter int NREQ      = 4,
  parameter int SLICE_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] gnt_o,
  output logic            busy_o
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int CW = $clog2(SLICE_LEN + 1);

  logic [1:0]    rsync_q;
  logic          rst_s;
  logic          busy_q, busy_d;
  logic [IW-1:0] own_q, own_d;
  logic [IW-1:0] rot_q, rot_d;
  logic [CW-1:0] cnt_q, cnt_d;
  policy_e       mode_q, mode_d, mode_eff;
  logic          pol_clr, lru_upd, fifo_pop;
  logic          ring_hit, lru_hit, fifo_vld, cand_hit;
  logic [IW-1:0] ring_idx, lru_win, fifo_head, cand_idx;
  logic          own_req, slice_end;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] v);
    return (int'(v) == NREQ - 1) ? '0 : v + 1'b1;
  endfunction

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  always_comb begin
    case (mode_i)
      3'd0:    mode_eff = POL_SLICE;
      3'd1:    mode_eff = POL_POLL;
      3'd2:    mode_eff = POL_LRU;
      3'd3:    mode_eff = POL_FIFO;
      default: mode_eff = POL_RING;
    endcase
  end

  mpa_ring_pick #(.N(NREQ), .IW(IW)) u_ring (
    .req(req_i), .start(rot_q), .hit(ring_hit), .idx(ring_idx)
  );

  mpa_lru_order #(.N(NREQ), .IW(IW)) u_lru (
    .clk(clk), .rst_n(rst_s), .clr(pol_clr), .upd(lru_upd),
    .upd_idx(own_q), .req(req_i), .hit(lru_hit), .win(lru_win)
  );

  mpa_arrival_queue #(.N(NREQ), .IW(IW)) u_fifo (
    .clk(clk), .rst_n(rst_s), .clr(pol_clr), .pop(fifo_pop),
    .req(req_i), .hold(gnt_o), .vld(fifo_vld), .head(fifo_head)
  );

  // candidate winner of the active policy
  always_comb begin
    case (mode_q)
      POL_POLL: begin cand_hit = req_i[rot_q];            cand_idx = rot_q;     end
      POL_LRU:  begin cand_hit = lru_hit;                 cand_idx = lru_win;   end
      POL_FIFO: begin cand_hit = fifo_vld && req_i[fifo_head]; cand_idx = fifo_head; end
      default:  begin cand_hit = ring_hit;                cand_idx = ring_idx;  end
    endcase
  end

  assign own_req   = req_i[own_q];
  assign slice_end = (mode_q == POL_SLICE) && (cnt_q == CW'(SLICE_LEN - 1));

  always_comb begin
    busy_d   = busy_q;
    own_d    = own_q;
    rot_d    = rot_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    pol_clr  = 1'b0;
    lru_upd  = 1'b0;
    fifo_pop = 1'b0;
    if (busy_q) begin
      if (!own_req || slice_end) begin
        busy_d  = 1'b0;
        lru_upd = (mode_q == POL_LRU);
      end else if (mode_q == POL_SLICE) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (mode_eff != mode_q) begin
      mode_d  = mode_eff;
      pol_clr = 1'b1;
      rot_d   = '0;
    end else begin
      fifo_pop = (mode_q == POL_FIFO) && fifo_vld;
      if (cand_hit) begin
        busy_d = 1'b1;
        own_d  = cand_idx;
        cnt_d  = '0;
        rot_d  = nxt(cand_idx);
      end else if (mode_q == POL_POLL) begin
        rot_d = nxt(rot_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      rot_q  <= '0;
      cnt_q  <= '0;
      mode_q <= POL_SLICE;
    end else begin
      busy_q <= busy_d;
      own_q  <= own_d;
      rot_q  <= rot_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    gnt_o = '0;
    if (busy_q) gnt_o[own_q] = 1'b1;
  end
  assign busy_o = busy_q;
endmodule

// File: rtl/mpa_arb_chk.sv
module mpa_arb_chk
  import mpa_pkg::*;
#(
  parameter int NREQ      = 4,
  parameter int SLICE_LEN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_i,
  input logic [NREQ-1:0] gnt_o,
  input logic            busy_o,
  input policy_e         mode_q
);
  logic [NREQ-1:0] prev_q;
  int              run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      run_q  <= 0;
    end else begin
      prev_q <= gnt_o;
      if (gnt_o == '0)          run_q <= 0;
      else if (gnt_o == prev_q) run_q <= run_q + 1;
      else                      run_q <= 1;
    end
  end

  // R1
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R1
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (gnt_o != '0));

  // R3
  grant_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ((gnt_o & $past(req_i)) != '0));

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ((gnt_o & req_i) != '0) && mode_q != POL_SLICE) |=> (gnt_o == $past(gnt_o)));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ((gnt_o & req_i) == '0)) |=> !busy_o);

  // R4
  slice_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_SLICE) |-> (run_q <= SLICE_LEN));

  // R9
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (!$past(busy_o) && !busy_o));
endmodule

bind mpol_bus_arbiter mpa_arb_chk #(.NREQ(NREQ), .SLICE_LEN(SLICE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_s), .req_i(req_i), .gnt_o(gnt_o),
  .busy_o(busy_o), .mode_q(mode_q)
);

// File: tb/tb_mpol_bus_arbiter.sv
`timescale 1ns/1ps
module tb_mpol_bus_arbiter;
  localparam int N  = 4;
  localparam int SL = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   mode;
  logic [N-1:0] req;
  logic [N-1:0] gnt;
  logic         busy;

  always #2 clk = ~clk;

  mpol_bus_arbiter #(.NREQ(N), .SLICE_LEN(SL)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_i(req),
    .gnt_o(gnt), .busy_o(busy)
  );

  typedef struct {
    int    idx;
    int    len;
    int    gap;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    chk = 0, err = 0, mchk = 0, merr = 0, mon_rd = 0;
  bit    sb_on = 1'b0, rand_on = 1'b0;
  int    hold[N], got[N], pend[N];
  int    starve = 0;

  task automatic expect_grant(int i, int l, int g, string t);
    item_t e;
    e.idx = i; e.len = l; e.gap = g; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic check(bit ok, string r, string what, int act, int expv);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  // one cycle of requester behaviour, run at the falling edge
  task automatic tick();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (req[i] && gnt[i]) begin
        got[i]++;
        if (got[i] >= hold[i]) req[i] = 1'b0;
      end
      if (req[i] && !gnt[i]) pend[i]++;
      else                   pend[i] = 0;
      if (pend[i] > 150) begin
        starve++;
        pend[i] = 0;
      end
      if (rand_on && !req[i] && !gnt[i] && $urandom_range(3) == 0) begin
        req[i]  = 1'b1;
        got[i]  = 0;
        hold[i] = $urandom_range(6, 1);
      end
    end
  endtask

  task automatic raise(logic [N-1:0] m);
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        req[i] = 1'b1;
        got[i] = 0;
      end
  endtask

  task automatic wait_done(string r);
    int n;
    n = 0;
    do begin
      tick();
      n++;
    end while ((req != '0 || gnt != '0) && n < 2000);
    tick();
    tick();
    check(n < 2000, r, "bus drained", n, 0);
    check(mon_rd == exp_q.size(), r, "grants observed", mon_rd, exp_q.size());
  endtask

  task automatic set_mode(logic [2:0] m);
    mode = m;
    repeat (3) tick();
  endtask

  // monitor: pops expected tenures as they complete
  int cur = -1, rl = 0, gp = 0, gsave = 0;
  always @(negedge clk) begin
    int g;
    if (rst_n) begin
      g = -1;
      for (int i = 0; i < N; i++) if (gnt[i]) g = i;
      if ($countones(gnt) > 1) begin
        merr++;
        $display("FAIL R1 grant not one-hot actual=%0d expected=1", $countones(gnt));
      end
      if (cur >= 0 && g != cur) begin
        if (sb_on) begin
          mchk++;
          if (mon_rd < exp_q.size()) begin
            if (cur != exp_q[mon_rd].idx || rl != exp_q[mon_rd].len ||
                (exp_q[mon_rd].gap >= 0 && gsave != exp_q[mon_rd].gap)) begin
              merr++;
              $display("FAIL %s tenure actual=%0d/%0d/%0d expected=%0d/%0d/%0d (unit/len/gap)",
                       exp_q[mon_rd].tag, cur, rl, gsave,
                       exp_q[mon_rd].idx, exp_q[mon_rd].len, exp_q[mon_rd].gap);
            end
            mon_rd++;
          end else begin
            merr++;
            $display("FAIL R3 unexpected tenure actual=%0d expected=%0d", cur, -1);
          end
        end
        cur = -1;
      end
      if (g >= 0 && cur < 0) begin
        cur = g; rl = 1; gsave = gp; gp = 0;
      end else if (g >= 0) begin
        rl++;
      end else begin
        gp++;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    mode  = 3'd0;
    req   = '0;
    for (int i = 0; i < N; i++) begin hold[i] = 2; got[i] = 0; pend[i] = 0; end
    repeat (3) @(negedge clk);
    check(gnt == '0, "R2", "grant in reset", gnt, 0);
    check(busy == 1'b0, "R2", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(gnt == '0, "R2", "grant after reset", gnt, 0);
    check(busy == 1'b0, "R2", "busy after reset", busy, 0);
    sb_on = 1'b1;

    // R4 time slice is the default policy (R2)
    hold[0] = 6; hold[2] = 6;
    expect_grant(0, 4, -1, "R4"); expect_grant(2, 4, 1, "R4");
    expect_grant(0, 2, 1, "R4");  expect_grant(2, 2, 1, "R4");
    raise(4'b0101);
    wait_done("R4");
    for (int i = 0; i < N; i++) hold[i] = 2;

    // R8 closed ring
    set_mode(3'd4);
    expect_grant(1, 2, -1, "R8"); expect_grant(3, 2, 1, "R8");
    raise(4'b1010); wait_done("R8");
    expect_grant(0, 2, -1, "R8"); expect_grant(1, 2, 1, "R8"); expect_grant(2, 2, 1, "R8");
    raise(4'b0111); wait_done("R8");
    expect_grant(0, 2, -1, "R8"); expect_grant(2, 2, 1, "R8");
    raise(4'b0101); wait_done("R8");
    // R3 owner keeps the bus for its whole request
    hold[3] = 5;
    expect_grant(3, 5, -1, "R3");
    raise(4'b1000); wait_done("R3");
    hold[3] = 2;

    // R5 polling: pointer walks 3, 0, 1 after unit 2
    set_mode(3'd1);
    expect_grant(2, 2, -1, "R5"); expect_grant(1, 2, 3, "R5");
    raise(4'b0100);
    do tick(); while (!gnt[2]);
    raise(4'b0010);
    wait_done("R5");

    // R6 least recently used
    set_mode(3'd2);
    expect_grant(3, 2, -1, "R6"); raise(4'b1000); wait_done("R6");
    expect_grant(2, 2, -1, "R6"); raise(4'b0100); wait_done("R6");
    expect_grant(3, 2, -1, "R6"); expect_grant(2, 2, 1, "R6");
    raise(4'b1100); wait_done("R6");
    expect_grant(1, 2, -1, "R6"); expect_grant(3, 2, 1, "R6"); expect_grant(2, 2, 1, "R6");
    raise(4'b1110); wait_done("R6");

    // R7 arrival order; R9 policy input toggled while busy
    set_mode(3'd3);
    hold[1] = 6;
    expect_grant(1, 6, -1, "R7"); expect_grant(3, 2, 1, "R7");
    expect_grant(0, 2, 1, "R7");  expect_grant(2, 2, 1, "R7");
    raise(4'b0010);
    do tick(); while (!gnt[1]);
    raise(4'b1000);
    tick();
    raise(4'b0101);
    mode = 3'd2;
    tick();
    tick();
    mode = 3'd3;
    wait_done("R9");
    hold[1] = 2;

    // R9 code 7 behaves as the closed ring after a fresh clear
    set_mode(3'd7);
    expect_grant(0, 2, -1, "R9"); expect_grant(2, 2, 1, "R9");
    raise(4'b0101); wait_done("R9");
    expect_grant(3, 2, -1, "R9"); expect_grant(1, 2, 1, "R9");
    raise(4'b1010); wait_done("R9");

    // R10 random traffic under every policy
    for (int m = 0; m < 5; m++) begin
      sb_on = 1'b0;
      set_mode(3'(m));
      starve  = 0;
      rand_on = 1'b1;
      repeat (500) tick();
      rand_on = 1'b0;
      wait_done("R10");
      check(starve == 0, "R10", "starved waits", starve, 0);
    end

    $display("CHECKS %0d ERRORS %0d", chk + mchk, err + merr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("CHECKS %0d ERRORS %0d", chk + mchk + 1, err + merr + 1);
    $finish;
  end
endmodule